// File: doc/BRIEF.md
# Three-Button Sequence Lock

This block is a Moore state machine that opens only when three push-buttons are pressed in one fixed order. Each button arrives as a press strobe one clock wide that upstream logic has already debounced and shaped. The lock begins in an idle state, numbered 0. Each correct press moves it one step forward. A wrong press sends it at once to an alarm state, so an intruder cannot find the code by trying presses one at a time. After the last correct press the lock enters an open state.

Both terminal states hold until reset. A seven-segment display follows the state at all times. It shows the step number while the code is being entered, the letter A in alarm, and the letter U when open. The code is a parameter: button codes are packed two bits per press, with the first press in the lowest bits. The default code is A, C, B, A.

Top module: `lock_combo_top`

## Requirements
- R1: While reset is held, and after it is released, the lock is idle at step 0. Both flags are low and the display shows the digit 0.
- R2: The three strobes are never high together. In a cycle with no strobe, the state and every output stay unchanged.
- R3: During entry, a strobe that matches the expected button moves the step up by exactly one at that rising edge. The display shows the new step number.
- R4: The correct strobe for the last press, after A, C and B, sets the unlock flag. The display then shows U, which is segments b, c, d, e and f, value 0x3E.
- R5: During entry, any strobe for a button other than the expected one sets the alarm flag, including a press from idle. The display then shows A, which is segments a, b, c, e, f and g, value 0x77.
- R6: Once in alarm, later presses of any button leave the alarm flag and the display unchanged.
- R7: Once open, later presses of any button leave the unlock flag and the display unchanged.
- R8: Asserting the active-low reset from alarm or from open returns the lock to idle at step 0.
- R9: The segment bus is active-high. Bit 0 drives segment a and bit 6 drives segment g. The digits 0, 1, 2 and 3 appear as 0x3F, 0x06, 0x5B and 0x4F.
- R10: The unlock and alarm flags are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset; asserts asynchronously and is released synchronously inside the block |
| btn_a | input | 1 | Single-cycle press strobe for button A |
| btn_b | input | 1 | Single-cycle press strobe for button B |
| btn_c | input | 1 | Single-cycle press strobe for button C |
| unlock | output | 1 | High while the lock is open |
| alarm | output | 1 | High while the lock is in alarm |
| seg | output | 7 | Active-high segment lines; bit 0 is segment a, bit 6 is segment g |

## Verification
The assertions assume that at most one press strobe is high in any cycle, because the buttons are mechanically exclusive. They also assume that each strobe lasts one cycle. The stimulus raises a single button for exactly one clock and returns all strobes to low before the next press. It never overlaps two buttons. Presses are issued only after the internal reset release has completed, so no press is lost to the synchroniser.

// File: rtl/lock_pkg.sv
package lock_pkg;

  localparam int BTN_W = 2;
  localparam logic [BTN_W-1:0] BTN_A = 2'd0;
  localparam logic [BTN_W-1:0] BTN_B = 2'd1;
  localparam logic [BTN_W-1:0] BTN_C = 2'd2;

  typedef enum logic [1:0] {
    MODE_ENTRY = 2'd0,
    MODE_OPEN  = 2'd1,
    MODE_ALARM = 2'd2
  } lock_mode_e;

  // segment bit 0 = a ... bit 6 = g, active-high
  localparam logic [6:0] GLYPH_LETTER_A = 7'h77;
  localparam logic [6:0] GLYPH_LETTER_U = 7'h3E;
  localparam logic [6:0] GLYPH_BLANK    = 7'h00;

  function automatic logic [6:0] digit_glyph(input int unsigned d);
    logic [6:0] g;
    case (d)
      0: g = 7'h3F;
      1: g = 7'h06;
      2: g = 7'h5B;
      3: g = 7'h4F;
      4: g = 7'h66;
      5: g = 7'h6D;
      6: g = 7'h7D;
      7: g = 7'h07;
      8: g = 7'h7F;
      9: g = 7'h6F;
      default: g = GLYPH_BLANK;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/lock_rst_sync.sv
module lock_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/lock_press_encoder.sv
module lock_press_encoder
  import lock_pkg::*;
(
  input  logic             press_a,
  input  logic             press_b,
  input  logic             press_c,
  output logic             press_valid,
  output logic [BTN_W-1:0] press_code
);
  // exactly one strobe counts as a press; anything else is ignored
  always_comb begin
    press_valid = 1'b0;
    press_code  = BTN_A;
    case ({press_c, press_b, press_a})
      3'b001: begin press_valid = 1'b1; press_code = BTN_A; end
      3'b010: begin press_valid = 1'b1; press_code = BTN_B; end
      3'b100: begin press_valid = 1'b1; press_code = BTN_C; end
      default: begin press_valid = 1'b0; press_code = BTN_A; end
    endcase
  end
endmodule

// File: rtl/lock_seq_fsm.sv
module lock_seq_fsm
  import lock_pkg::*;
#(
  parameter int                    SEQ_LEN = 4,
  parameter logic [SEQ_LEN*2-1:0]  COMBO   = {BTN_A, BTN_B, BTN_C, BTN_A},
  localparam int                   STEP_W  = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              press_valid,
  input  logic [BTN_W-1:0]  press_code,
  output lock_mode_e        mode,
  output logic [STEP_W-1:0] step
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(SEQ_LEN - 1);

  lock_mode_e        mode_q, mode_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [BTN_W-1:0]  want_code;
  logic              upd_en;

  always_comb want_code = COMBO[BTN_W*int'(step_q) +: BTN_W];

  assign upd_en = press_valid && (mode_q == MODE_ENTRY);

  always_comb begin
    mode_d = mode_q;
    step_d = step_q;
    if (press_code != want_code) begin
      mode_d = MODE_ALARM;
    end else if (step_q == LAST_STEP) begin
      mode_d = MODE_OPEN;
    end else begin
      step_d = step_q + STEP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_ENTRY;
      step_q <= '0;
    end else if (upd_en) begin
      mode_q <= mode_d;
      step_q <= step_d;
    end
  end

  assign mode = mode_q;
  assign step = step_q;

  assert_alarm_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_ALARM) |=> (mode_q == MODE_ALARM));

  assert_open_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_OPEN) |=> (mode_q == MODE_OPEN));

  assert_quiet_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !press_valid |=> ($stable(mode_q) && $stable(step_q)));

  assert_wrong_alarm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_ENTRY && press_valid && press_code != want_code) |=> (mode_q == MODE_ALARM));

  assert_step_plus_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_ENTRY && press_valid && press_code == want_code && step_q != LAST_STEP)
      |=> (mode_q == MODE_ENTRY && step_q == $past(step_q) + STEP_W'(1)));
endmodule

// File: rtl/lock_seg_decode.sv
module lock_seg_decode
  import lock_pkg::*;
#(
  parameter int STEP_W = 2
) (
  input  lock_mode_e        mode,
  input  logic [STEP_W-1:0] step,
  output logic [6:0]        seg
);
  always_comb begin
    case (mode)
      MODE_OPEN:  seg = GLYPH_LETTER_U;
      MODE_ALARM: seg = GLYPH_LETTER_A;
      default:    seg = digit_glyph(int'(step));
    endcase
  end
endmodule

// File: rtl/lock_combo_top.sv
module lock_combo_top
  import lock_pkg::*;
#(
  parameter int                   SEQ_LEN = 4,
  parameter logic [SEQ_LEN*2-1:0] COMBO   = {BTN_A, BTN_B, BTN_C, BTN_A},
  parameter int                   SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       btn_a,
  input  logic       btn_b,
  input  logic       btn_c,
  output logic       unlock,
  output logic       alarm,
  output logic [6:0] seg
);
  localparam int STEP_W = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;

  logic              rst_sync_n;
  logic              press_valid;
  logic [BTN_W-1:0]  press_code;
  lock_mode_e        mode;
  logic [STEP_W-1:0] step;

  lock_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  lock_press_encoder u_enc (
    .press_a(btn_a), .press_b(btn_b), .press_c(btn_c),
    .press_valid(press_valid), .press_code(press_code));

  lock_seq_fsm #(.SEQ_LEN(SEQ_LEN), .COMBO(COMBO)) u_fsm (
    .clk(clk), .rst_n(rst_sync_n),
    .press_valid(press_valid), .press_code(press_code),
    .mode(mode), .step(step));

  lock_seg_decode #(.STEP_W(STEP_W)) u_seg (
    .mode(mode), .step(step), .seg(seg));

  assign unlock = (mode == MODE_OPEN);
  assign alarm  = (mode == MODE_ALARM);

  assert_buttons_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({btn_a, btn_b, btn_c}));

  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(unlock && alarm));

  assert_seg_lit_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    seg != 7'h00);
endmodule

// File: tb/sim_lock_combo_top.sv
module sim_lock_combo_top;
  logic clk = 1'b0;
  logic rst_n;
  logic btn_a, btn_b, btn_c;
  logic unlock, alarm;
  logic [6:0] seg;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  // reference model: 0 entry, 1 open, 2 alarm
  int combo_q[$] = '{0, 2, 1, 0};
  int m_mode;
  int m_step;

  always #10 clk = ~clk;

  lock_combo_top u0 (
    .clk(clk), .rst_n(rst_n), .btn_a(btn_a), .btn_b(btn_b), .btn_c(btn_c),
    .unlock(unlock), .alarm(alarm), .seg(seg));

  function automatic logic [6:0] exp_seg();
    if (m_mode == 1) return 7'h3E;
    if (m_mode == 2) return 7'h77;
    case (m_step)
      0: return 7'h3F;
      1: return 7'h06;
      2: return 7'h5B;
      default: return 7'h4F;
    endcase
  endfunction

  task automatic check_val(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic compare();
    check_val(cur_req, seg, exp_seg());
    check_val(cur_req, unlock, m_mode == 1);
    check_val(cur_req, alarm, m_mode == 2);
    check_val("R10", unlock & alarm, 0);
  endtask

  task automatic model_press(input int code);
    if (m_mode != 0) return;
    if (code != combo_q[m_step]) m_mode = 2;
    else if (m_step == combo_q.size() - 1) m_mode = 1;
    else m_step++;
  endtask

  // called at a negedge; returns at the following negedge after comparing
  task automatic press(input int code);
    btn_a = (code == 0);
    btn_b = (code == 1);
    btn_c = (code == 2);
    @(posedge clk);
    model_press(code);
    @(negedge clk);
    btn_a = 1'b0; btn_b = 1'b0; btn_c = 1'b0;
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
    end
  endtask

  task automatic do_reset();
    cur_req = "R1";
    rst_n = 1'b0;
    m_mode = 0;
    m_step = 0;
    #1;
    compare();
    idle(2);
    rst_n = 1'b1;
    idle(3);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    btn_a = 1'b0; btn_b = 1'b0; btn_c = 1'b0;
    rst_n = 1'b0;
    m_mode = 0; m_step = 0;
    @(negedge clk);
    do_reset();

    cur_req = "R2"; idle(3);
    cur_req = "R3"; press(0);
    check_val("R9", seg, 7'h06);
    press(2);
    check_val("R9", seg, 7'h5B);
    cur_req = "R2"; idle(4);
    cur_req = "R3"; press(1);
    check_val("R9", seg, 7'h4F);
    cur_req = "R4"; press(0);
    check_val("R4", unlock, 1);
    check_val("R4", seg, 7'h3E);
    cur_req = "R7"; press(1); press(2); press(0); idle(2);
    check_val("R7", unlock, 1);

    cur_req = "R8"; rst_n = 1'b0; m_mode = 0; m_step = 0; #1; compare();
    check_val("R8", seg, 7'h3F);
    idle(1); rst_n = 1'b1; idle(3);

    cur_req = "R5"; press(1);
    check_val("R5", seg, 7'h77);
    cur_req = "R6"; press(0); press(2); press(1); idle(2);
    check_val("R6", alarm, 1);

    cur_req = "R8"; rst_n = 1'b0; m_mode = 0; m_step = 0; #1; compare();
    idle(1); rst_n = 1'b1; idle(3);

    cur_req = "R3"; press(0); press(2);
    cur_req = "R5"; press(2);
    check_val("R5", alarm, 1);

    do_reset();
    cur_req = "R3"; press(0); press(2); press(1);
    cur_req = "R5"; press(1);
    check_val("R5", unlock, 0);

    do_reset();
    cur_req = "R4"; press(0); idle(1); press(2); idle(2); press(1); press(0);
    check_val("R4", unlock, 1);
    cur_req = "R7"; idle(3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule